// File: doc/BRIEF.md
# Hardware Repeat-Loop Controller

This block gives a DSP-oriented CPU with 16-bit instructions a loop that costs no branch instruction. It keeps a 12-bit iteration count (the repeat-count field of the status register), a loop-start address and a loop-end address. A small set of system-control opcodes is decoded in the execute stage. These opcodes load the count from an immediate or from a general register, load either loop bound from a PC-relative displacement scaled by two, and copy either bound back into a general register.

On every fetch the controller compares the fetch address with the loop-end address. When iterations remain, it redirects the next fetch to the loop-start address and counts down by one. The last pass through the loop falls through to the code after it. Every supported opcode finishes in one cycle and leaves the T flag alone. The count field is brought out so that the status register can be assembled around it.

Top module: `zloop_unit`

## Requirements
- R1: After reset the loop-start address, loop-end address and count are all 0, no redirect is requested and no write-back is issued.
- R2: Opcode `0x82ii` (bits 15..8 = 0x82) sets the count to the 8-bit value ii, zero-extended so that the top four bits of the field are 0. The new count is visible on the count output from the next cycle.
- R3: Opcode `0x4n14` (bits 15..12 = 0x4, bits 7..0 = 0x14) sets the count to bits 11..0 of the register read value.
- R4: Opcode `0x8Cdd` loads the loop start with pcCur + 2*dd, where dd is zero-extended.
- R5: Opcode `0x8Edd` loads the loop end with pcCur + 2*dd, where dd is zero-extended.
- R6: Opcode `0x0n62` (bits 15..12 = 0, bits 7..0 = 0x62) issues, one cycle later, a write-back of the loop start into register n (n = bits 11..8).
- R7: Opcode `0x0n72` issues, one cycle later, a write-back of the loop end into register n.
- R8: A valid fetch whose address equals the loop end while the count is above 1 raises the redirect in the same cycle, with the loop start as target. The count then drops by one.
- R9: A valid fetch at the loop end with count 1 gives no redirect and leaves the count at 0. With count 0 there is no redirect and the count stays 0.
- R10: If a count load and a loop-end fetch happen in the same cycle, the load wins and the count is not decremented.
- R11: An instruction that is not valid, or an opcode outside the set above, changes no register and issues no write-back.
- R12: With the fetch strobe low there is no redirect and no decrement, even at the loop end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction in execute is valid |
| instrWord | input | 16 | Instruction in execute |
| gprRdData | input | 32 | Value of the general register named in bits 11..8 |
| pcCur | input | 32 | Address of the executing instruction plus 4 |
| fetchValid | input | 1 | A fetch happens this cycle |
| fetchAddr | input | 32 | Address being fetched |
| redirValid | output | 1 | Next fetch must go to redirTarget |
| redirTarget | output | 32 | Loop-start address |
| wbEn | output | 1 | General-register write-back enable |
| wbIdx | output | 4 | Write-back register index |
| wbData | output | 32 | Write-back data |
| rcField | output | 12 | Current repeat count (status bits 27..16) |

## Verification
The loop is run from a count of 3 down through 2 and 1 to 0, and once more at 0. This separates the ordinary loop-back, the fall-through on the last pass and the idle state. Fetches at an address other than the loop end, and fetches at the loop end with the strobe low, tell a true address match apart from a match taken on the address alone. The count loads use register values with set upper bits and an immediate that follows a wide load, which shows the field is masked and zero-extended. A displacement of 0xFF shows that it is zero-extended and not sign-extended. A count load that lands on a loop-end fetch shows that the load takes priority over the decrement.

// File: rtl/zloop_pkg.sv
package zloop_pkg;
  localparam int IMM_W = 8;
  localparam int IDX_W = 4;

  // Major opcode bytes (bits 15..8) for the displacement and immediate forms
  localparam logic [7:0] OP_RC_IMM = 8'h82;
  localparam logic [7:0] OP_LD_BEG = 8'h8C;
  localparam logic [7:0] OP_LD_END = 8'h8E;
  // Top nibble and low byte for the register forms
  localparam logic [3:0] GRP_RC_REG = 4'h4;
  localparam logic [7:0] SUB_RC_REG = 8'h14;
  localparam logic [3:0] GRP_STORE  = 4'h0;
  localparam logic [7:0] SUB_RD_BEG = 8'h62;
  localparam logic [7:0] SUB_RD_END = 8'h72;

  typedef struct packed {
    logic             setRcImm;
    logic             setRcReg;
    logic             ldBegin;
    logic             ldEnd;
    logic             rdBegin;
    logic             rdEnd;
    logic [IDX_W-1:0] regIdx;
    logic [IMM_W-1:0] imm;
  } ctrl_t;
endpackage

// File: rtl/zloop_decode.sv
module zloop_decode
  import zloop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [15:0] instrWord,
  output ctrl_t       ctrl
);
  logic [7:0] hiByte;
  logic [7:0] loByte;
  logic [3:0] topNib;

  assign hiByte = instrWord[15:8];
  assign loByte = instrWord[7:0];
  assign topNib = instrWord[15:12];

  always_comb begin
    ctrl          = '0;
    ctrl.regIdx   = instrWord[11:8];
    ctrl.imm      = instrWord[7:0];
    if (instrValid) begin
      ctrl.setRcImm = (hiByte == OP_RC_IMM);
      ctrl.ldBegin  = (hiByte == OP_LD_BEG);
      ctrl.ldEnd    = (hiByte == OP_LD_END);
      ctrl.setRcReg = (topNib == GRP_RC_REG) && (loByte == SUB_RC_REG);
      ctrl.rdBegin  = (topNib == GRP_STORE)  && (loByte == SUB_RD_BEG);
      ctrl.rdEnd    = (topNib == GRP_STORE)  && (loByte == SUB_RD_END);
    end
  end

  // R11: at most one strobe, and none without a valid instruction
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.setRcImm, ctrl.setRcReg, ctrl.ldBegin, ctrl.ldEnd, ctrl.rdBegin, ctrl.rdEnd}));
  // R11
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !(ctrl.setRcImm || ctrl.setRcReg || ctrl.ldBegin || ctrl.ldEnd || ctrl.rdBegin || ctrl.rdEnd));
endmodule

// File: rtl/zloop_datapath.sv
module zloop_datapath
  import zloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RC_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] gprRdData,
  input  logic [ADDR_W-1:0] pcCur,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              redirValid,
  output logic [ADDR_W-1:0] redirTarget,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData,
  output logic [RC_W-1:0]   rcField
);
  localparam logic [RC_W-1:0] RC_ONE = RC_W'(1);

  logic [ADDR_W-1:0] beginReg;
  logic [ADDR_W-1:0] endReg;
  logic [RC_W-1:0]   rcReg;
  logic [ADDR_W-1:0] relAddr;
  logic [RC_W-1:0]   rcLoad;
  logic              rcWrite;
  logic              endHit;
  logic              unusedHi;

  assign unusedHi = ^gprRdData[DATA_W-1:RC_W];

  // zero-extended displacement, halfword-scaled
  assign relAddr = pcCur + (ADDR_W'(ctrl.imm) << 1);
  assign rcWrite = ctrl.setRcImm | ctrl.setRcReg;
  assign rcLoad  = ctrl.setRcReg ? gprRdData[RC_W-1:0] : RC_W'(ctrl.imm);

  assign endHit      = fetchValid && (fetchAddr == endReg) && (rcReg != '0);
  assign redirValid  = endHit && (rcReg > RC_ONE);
  assign redirTarget = beginReg;
  assign rcField     = rcReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beginReg <= '0;
      endReg   <= '0;
    end else begin
      if (ctrl.ldBegin) beginReg <= relAddr;
      if (ctrl.ldEnd)   endReg   <= relAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        rcReg <= '0;
    else if (rcWrite) rcReg <= rcLoad;
    else if (endHit)  rcReg <= rcReg - RC_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbEn   <= 1'b0;
      wbIdx  <= '0;
      wbData <= '0;
    end else begin
      wbEn  <= ctrl.rdBegin | ctrl.rdEnd;
      wbIdx <= ctrl.regIdx;
      if (ctrl.rdBegin)    wbData <= DATA_W'(beginReg);
      else if (ctrl.rdEnd) wbData <= DATA_W'(endReg);
    end
  end

  // R8
  loop_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && !rcWrite) |=> (rcReg == $past(rcReg) - RC_ONE));
  // R9
  idle_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rcReg == '0 && !rcWrite) |=> (rcReg == '0));
  // R2
  imm_upper_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.setRcImm |=> (rcReg[RC_W-1:IMM_W] == '0));
  // R12
  no_fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid && !rcWrite) |=> $stable(rcReg));
  // R6
  wb_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rdBegin || ctrl.rdEnd) |=> wbEn);
  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.setRcImm && endHit) |=> (rcReg == RC_W'($past(ctrl.imm))));
endmodule

// File: rtl/zloop_unit.sv
module zloop_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RC_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [15:0]       instrWord,
  input  logic [DATA_W-1:0] gprRdData,
  input  logic [ADDR_W-1:0] pcCur,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              redirValid,
  output logic [ADDR_W-1:0] redirTarget,
  output logic              wbEn,
  output logic [3:0]        wbIdx,
  output logic [DATA_W-1:0] wbData,
  output logic [RC_W-1:0]   rcField
);
  zloop_pkg::ctrl_t ctrl;

  zloop_decode u_dec (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .ctrl       (ctrl)
  );

  zloop_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RC_W   (RC_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .gprRdData   (gprRdData),
    .pcCur       (pcCur),
    .fetchValid  (fetchValid),
    .fetchAddr   (fetchAddr),
    .redirValid  (redirValid),
    .redirTarget (redirTarget),
    .wbEn        (wbEn),
    .wbIdx       (wbIdx),
    .wbData      (wbData),
    .rcField     (rcField)
  );
endmodule

// File: tb/zloop_unit_tb.sv
module zloop_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [31:0] gprRdData = '0;
  logic [31:0] pcCur = '0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        redirValid;
  logic [31:0] redirTarget;
  logic        wbEn;
  logic [3:0]  wbIdx;
  logic [31:0] wbData;
  logic [11:0] rcField;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0]  idx;
    logic [31:0] data;
    string       req;
  } wb_item_t;
  wb_item_t expQ[$];

  logic [31:0] expBegin = '0;
  logic [31:0] expEnd = '0;
  logic [11:0] expRc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zloop_unit u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .gprRdData(gprRdData), .pcCur(pcCur), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .redirValid(redirValid), .redirTarget(redirTarget), .wbEn(wbEn), .wbIdx(wbIdx),
    .wbData(wbData), .rcField(rcField)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected write-backs away from the clock edge
  always @(negedge clk) begin
    if (rstN && wbEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected write-back", {28'd0, wbIdx}, 32'hFFFF_FFFF);
      end else begin
        wb_item_t it;
        it = expQ.pop_front();
        check(wbIdx == it.idx, it.req, {28'd0, wbIdx}, {28'd0, it.idx});
        check(wbData == it.data, it.req, wbData, it.data);
      end
    end
  end

  // one cycle: drive, sample redirect before the edge, update model
  task automatic step(input bit iv, input logic [15:0] iw, input logic [31:0] gpr,
                      input logic [31:0] pc, input bit fv, input logic [31:0] fa,
                      input bit expRedir, input string req);
    instrValid = iv; instrWord = iw; gprRdData = gpr; pcCur = pc;
    fetchValid = fv; fetchAddr = fa;
    #1;
    check(redirValid == expRedir, req, {31'd0, redirValid}, {31'd0, expRedir});
    if (expRedir) check(redirTarget == expBegin, req, redirTarget, expBegin);
    @(posedge clk);
    #1;
    instrValid = 1'b0; fetchValid = 1'b0;
  endtask

  task automatic setRcImm(input logic [7:0] v, input string req);
    step(1'b1, {8'h82, v}, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, req);
    expRc = {4'd0, v};
    check(rcField == expRc, req, {20'd0, rcField}, {20'd0, expRc});
  endtask

  task automatic readBound(input bit endSel, input logic [3:0] n, input string req);
    wb_item_t it;
    it.idx = n; it.data = endSel ? expEnd : expBegin; it.req = req;
    expQ.push_back(it);
    step(1'b1, {4'h0, n, endSel ? 8'h72 : 8'h62}, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, req);
  endtask

  task automatic loopFetch(input bit fv, input logic [31:0] fa, input string req);
    bit hit;
    hit = fv && (fa == expEnd) && (expRc != 0);
    step(1'b0, 16'h0, 32'h0, 32'h0, fv, fa, hit && (expRc > 1), req);
    if (hit) expRc = expRc - 12'd1;
    check(rcField == expRc, req, {20'd0, rcField}, {20'd0, expRc});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check(rcField == 12'd0, "R1 count", {20'd0, rcField}, 32'd0);
    check(!redirValid && !wbEn, "R1 outputs", {30'd0, redirValid, wbEn}, 32'd0);
    readBound(1'b0, 4'd1, "R1 start reads 0");
    readBound(1'b1, 4'd2, "R1 end reads 0");

    // R2 / R3 count loads
    setRcImm(8'hFF, "R2 imm FF");
    step(1'b1, 16'h4314, 32'hABCD_E123, 32'h0, 1'b0, 32'h0, 1'b0, "R3");
    expRc = 12'h123;
    check(rcField == expRc, "R3 reg load", {20'd0, rcField}, {20'd0, expRc});
    setRcImm(8'h05, "R2 upper cleared");

    // R4 / R5 bound loads
    step(1'b1, 16'h8C10, 32'h0, 32'h0000_1000, 1'b0, 32'h0, 1'b0, "R4");
    expBegin = 32'h0000_1020;
    step(1'b1, 16'h8EFF, 32'h0, 32'h0000_2000, 1'b0, 32'h0, 1'b0, "R5");
    expEnd = 32'h0000_21FE;
    // R6 / R7 read-back
    readBound(1'b0, 4'd3, "R6 start readback");
    readBound(1'b1, 4'd15, "R7 end readback");

    // R8 / R9 loop from 3 to 0
    setRcImm(8'd3, "R8 setup");
    loopFetch(1'b1, 32'h0000_21FC, "R8 other addr no redirect");
    loopFetch(1'b1, expEnd, "R8 redirect at 3");
    loopFetch(1'b0, expEnd, "R12 no fetch strobe");
    loopFetch(1'b1, expEnd, "R8 redirect at 2");
    loopFetch(1'b1, expEnd, "R9 fall through at 1");
    loopFetch(1'b1, expEnd, "R9 idle at 0");

    // R10 load wins over decrement
    setRcImm(8'd3, "R10 setup");
    step(1'b1, 16'h8209, 32'h0, 32'h0, 1'b1, expEnd, 1'b1, "R10 redirect");
    expRc = 12'd9;
    check(rcField == expRc, "R10 load wins", {20'd0, rcField}, {20'd0, expRc});

    // R11 ignored instructions
    step(1'b1, 16'h8D10, 32'hFFFF_FFFF, 32'h0000_5000, 1'b0, 32'h0, 1'b0, "R11 bad opcode");
    step(1'b0, 16'h8C20, 32'h0, 32'h0000_5000, 1'b0, 32'h0, 1'b0, "R11 not valid");
    step(1'b0, 16'h8205, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, "R11 not valid count");
    check(rcField == expRc, "R11 count kept", {20'd0, rcField}, {20'd0, expRc});
    readBound(1'b0, 4'd7, "R11 start kept");
    readBound(1'b1, 4'd8, "R11 end kept");

    repeat (3) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R6 missing write-back", expQ.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule